// File: doc/BRIEF.md
# Dual-Width Carry and Overflow Flag Unit

This block is the fixed-point add, subtract and negate datapath of a processor that runs in either a 64-bit or a 32-bit mode. It also keeps the status flags those operations produce. Each operation is presented for one cycle. Its result and flags appear in registers on the next clock edge.

Every carry flag and every overflow flag is kept twice. One copy follows the current mode. The second copy always describes the low 32-bit half, whatever the mode. A summary-overflow bit accumulates overflows until software clears it. Multiply and divide overflow is computed elsewhere and arrives as two inputs, one for the 32-bit result and one for the 64-bit result; this block only folds it into the flags. A move operation copies the four dual-width flags into one 4-bit field of an eight-field condition register.

Top module: `fxu_flag_unit`

## Requirements
- R1: While `rstN` is low, `result`, `status` and `condReg` are all zero.
- R2: Operation select encodings are 0 add (A+B), 1 subtract-from (B-A, computed as ~A+B+1), 2 extended add (A+B+carryIn) and 3 extended subtract-from (~A+B+carryIn). One edge after the operation, `result` holds the 64-bit sum. CA (`status[1]`) holds the carry out of bit 63 in 64-bit mode (`mode64`=1) and the carry out of bit 31 in 32-bit mode.
- R3: For operations 0 to 3, CA32 (`status[0]`) holds the carry out of bit 31 in both modes, so CA equals CA32 in 32-bit mode.
- R4: Operations 0 to 3 update CA and CA32 whether `oeEn` is high or low. No other operation changes them, except the status write.
- R5: For operations 0 to 3 with `oeEn` high, OV (`status[3]`) is the signed overflow of the 64-bit sum in 64-bit mode and of the low 32-bit sum in 32-bit mode. OV32 (`status[2]`) is the low 32-bit signed overflow in both modes. With `oeEn` low, OV and OV32 keep their values.
- R6: SO (`status[4]`) is ORed with the new OV on every overflow update. It returns to zero only through the status write or reset.
- R7: Operation 4 (negate) loads the two's complement of A into `result`. With `oeEn` high it sets both OV and OV32 to 1 exactly when A is the most negative value for the mode: 0x8000_0000_0000_0000 in 64-bit mode, or a low half of 0x8000_0000 in 32-bit mode. Otherwise it sets both to 0.
- R8: Operation 5 (multiply/divide result) loads A into `result`. With `oeEn` high, SO, OV and OV32 take `extOv32` when `wordOp` is 1 and `extOv64` when it is 0.
- R9: Operation 6 writes {OV, OV32, CA, CA32}, most significant first, into condition field `crSel`. Field 0 is `condReg[31:28]` and field k is `condReg[31-4k:28-4k]`. The other fields, `result` and `status` do not change.
- R10: Operation 7 loads A[4:0] into `status` as {SO, OV, OV32, CA, CA32}. `result` and `condReg` do not change.
- R11: While `opValid` is low, `result`, `status` and `condReg` keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| opValid | input | 1 | An operation is presented this cycle |
| opSel | input | 3 | Operation select (see R2, R7 to R10) |
| opA | input | 64 | Operand A; also the product/quotient and the status write value |
| opB | input | 64 | Operand B |
| carryIn | input | 1 | Carry input for the extended forms |
| mode64 | input | 1 | 1 selects 64-bit mode, 0 selects 32-bit mode |
| oeEn | input | 1 | Overflow-enable: allows SO, OV and OV32 to update |
| wordOp | input | 1 | Multiply/divide was a 32-bit (word) form |
| extOv32 | input | 1 | Overflow of a 32-bit multiply/divide result |
| extOv64 | input | 1 | Overflow of a 64-bit multiply/divide result |
| crSel | input | 3 | Destination field of the condition move |
| result | output | 64 | Registered result |
| status | output | 5 | {SO, OV, OV32, CA, CA32} |
| condReg | output | 32 | Eight 4-bit condition fields |

## Verification
Every output of this block is due on the first rising edge after an operation is presented, because the result, the five flags and the condition fields all sit one register deep. The bench drives each operation one nanosecond after an edge. Its behavioural model advances by one operation, and `result`, `status` and `condReg` are compared against the model one nanosecond after the following edge. A condition move therefore copies the flags as they stood before that edge, and the model reproduces this. Directed cases cover the carry and overflow boundaries at bit 31 and bit 63 in both modes, the most-negative negate values, sticky SO and its clearing, and the first and last condition fields. A long run of operations with biased random operands follows.

// File: rtl/fxu_flag_pkg.sv
package fxu_flag_pkg;

  localparam int STAT_W = 5;

  typedef enum logic [2:0] {
    OP_ADD     = 3'd0,
    OP_SUBF    = 3'd1,
    OP_ADDE    = 3'd2,
    OP_SUBFE   = 3'd3,
    OP_NEG     = 3'd4,
    OP_MULDIV  = 3'd5,
    OP_MOVCR   = 3'd6,
    OP_SETSTAT = 3'd7
  } fxuOp_e;

  typedef enum logic [1:0] {
    CIN_ZERO = 2'd0,
    CIN_ONE  = 2'd1,
    CIN_EXT  = 2'd2
  } cinSel_e;

  typedef enum logic [1:0] {
    OVS_ADD = 2'd0,
    OVS_NEG = 2'd1,
    OVS_EXT = 2'd2
  } ovSrc_e;

  // strobes from control to datapath
  typedef struct packed {
    logic    loadRes;
    logic    invA;
    logic    zeroB;
    logic    passA;
    cinSel_e cinSel;
    logic    updCarry;
    logic    updOv;
    ovSrc_e  ovSrc;
    logic    writeCr;
    logic    writeStat;
  } fxuStrobe_t;

endpackage

// File: rtl/fxu_flag_ctrl.sv
module fxu_flag_ctrl
  import fxu_flag_pkg::*;
(
  input  logic       opValid,
  input  logic [2:0] opSel,
  input  logic       oeEn,
  output fxuStrobe_t stb
);

  always_comb begin
    stb        = '0;
    stb.cinSel = CIN_ZERO;
    stb.ovSrc  = OVS_ADD;
    if (opValid) begin
      unique case (fxuOp_e'(opSel))
        OP_ADD: begin
          stb.loadRes  = 1'b1;
          stb.updCarry = 1'b1;
          stb.updOv    = oeEn;
        end
        OP_SUBF: begin
          stb.loadRes  = 1'b1;
          stb.invA     = 1'b1;
          stb.cinSel   = CIN_ONE;
          stb.updCarry = 1'b1;
          stb.updOv    = oeEn;
        end
        OP_ADDE: begin
          stb.loadRes  = 1'b1;
          stb.cinSel   = CIN_EXT;
          stb.updCarry = 1'b1;
          stb.updOv    = oeEn;
        end
        OP_SUBFE: begin
          stb.loadRes  = 1'b1;
          stb.invA     = 1'b1;
          stb.cinSel   = CIN_EXT;
          stb.updCarry = 1'b1;
          stb.updOv    = oeEn;
        end
        OP_NEG: begin
          stb.loadRes = 1'b1;
          stb.invA    = 1'b1;
          stb.zeroB   = 1'b1;
          stb.cinSel  = CIN_ONE;
          stb.updOv   = oeEn;
          stb.ovSrc   = OVS_NEG;
        end
        OP_MULDIV: begin
          stb.loadRes = 1'b1;
          stb.passA   = 1'b1;
          stb.updOv   = oeEn;
          stb.ovSrc   = OVS_EXT;
        end
        OP_MOVCR:   stb.writeCr   = 1'b1;
        OP_SETSTAT: stb.writeStat = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/fxu_flag_datapath.sv
module fxu_flag_datapath
  import fxu_flag_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int CR_FIELDS = 8,
  parameter int FIELD_W   = 4,
  localparam int HALF_W   = DATA_W / 2,
  localparam int CR_W     = CR_FIELDS * FIELD_W,
  localparam int SEL_W    = $clog2(CR_FIELDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  fxuStrobe_t        stb,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  input  logic              mode64,
  input  logic              wordOp,
  input  logic              extOv32,
  input  logic              extOv64,
  input  logic [SEL_W-1:0]  crSel,
  output logic [DATA_W-1:0] resQ,
  output logic [STAT_W-1:0] statQ,
  output logic [CR_W-1:0]   crQ
);

  logic [DATA_W-1:0]  opX, opY, sum, resNext;
  logic               cinBit;
  logic [HALF_W:0]    lowSum, highSum;
  logic               carryLow, carryFull, ovfLow, ovfFull;
  logic               caNext, ca32Next, ovNext, ov32Next;
  logic               soQ, ovQ, ov32Q, caQ, ca32Q;
  logic [FIELD_W-1:0] fieldQ [CR_FIELDS];

  // split adder: low half carry feeds high half
  always_comb begin
    opX = stb.invA  ? ~opA : opA;
    opY = stb.zeroB ? '0   : opB;
    unique case (stb.cinSel)
      CIN_ONE: cinBit = 1'b1;
      CIN_EXT: cinBit = carryIn;
      default: cinBit = 1'b0;
    endcase
    lowSum  = {1'b0, opX[HALF_W-1:0]} + {1'b0, opY[HALF_W-1:0]}
            + (HALF_W+1)'(cinBit);
    highSum = {1'b0, opX[DATA_W-1:HALF_W]} + {1'b0, opY[DATA_W-1:HALF_W]}
            + (HALF_W+1)'(lowSum[HALF_W]);
    sum       = {highSum[HALF_W-1:0], lowSum[HALF_W-1:0]};
    carryLow  = lowSum[HALF_W];
    carryFull = highSum[HALF_W];
    ovfLow  = (opX[HALF_W-1] == opY[HALF_W-1]) && (sum[HALF_W-1] != opX[HALF_W-1]);
    ovfFull = (opX[DATA_W-1] == opY[DATA_W-1]) && (sum[DATA_W-1] != opX[DATA_W-1]);
    resNext = stb.passA ? opA : sum;
  end

  // mode-following and low-half flag copies
  always_comb begin
    caNext   = mode64 ? carryFull : carryLow;
    ca32Next = carryLow;
    unique case (stb.ovSrc)
      OVS_NEG: begin
        ovNext   = mode64 ? ovfFull : ovfLow;
        ov32Next = ovNext;
      end
      OVS_EXT: begin
        ovNext   = wordOp ? extOv32 : extOv64;
        ov32Next = ovNext;
      end
      default: begin
        ovNext   = mode64 ? ovfFull : ovfLow;
        ov32Next = ovfLow;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      resQ  <= '0;
      soQ   <= 1'b0;
      ovQ   <= 1'b0;
      ov32Q <= 1'b0;
      caQ   <= 1'b0;
      ca32Q <= 1'b0;
    end else begin
      if (stb.loadRes) resQ <= resNext;
      if (stb.writeStat) begin
        {soQ, ovQ, ov32Q, caQ, ca32Q} <= opA[STAT_W-1:0];
      end else begin
        if (stb.updCarry) begin
          caQ   <= caNext;
          ca32Q <= ca32Next;
        end
        if (stb.updOv) begin
          ovQ   <= ovNext;
          ov32Q <= ov32Next;
          soQ   <= soQ | ovNext;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int f = 0; f < CR_FIELDS; f++) fieldQ[f] <= '0;
    end else if (stb.writeCr) begin
      for (int f = 0; f < CR_FIELDS; f++)
        if (crSel == SEL_W'(f)) fieldQ[f] <= FIELD_W'({ovQ, ov32Q, caQ, ca32Q});
    end
  end

  // field 0 occupies the most significant nibble
  for (genvar g = 0; g < CR_FIELDS; g++) begin : g_crMap
    assign crQ[CR_W-1-FIELD_W*g -: FIELD_W] = fieldQ[g];
  end

  assign statQ = {soQ, ovQ, ov32Q, caQ, ca32Q};

  // R3: in 32-bit mode the two carry copies agree after a carry update
  p_ca_pair_r3: assert property (@(posedge clk) disable iff (!rstN)
    (stb.updCarry && !stb.writeStat && !mode64) |=> (caQ == ca32Q));

  // R4: carries move only on carry-producing ops or a status write
  p_carry_hold_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.updCarry && !stb.writeStat) |=> ($stable(caQ) && $stable(ca32Q)));

  // R5: overflow copies held without overflow enable
  p_ov_gated_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.updOv && !stb.writeStat) |=> ($stable(ovQ) && $stable(ov32Q)));

  // R6: summary overflow never drops without a status write
  p_so_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    (soQ && !stb.writeStat) |=> soQ);

  // R6: a new overflow always lands in SO
  p_so_catch_r6: assert property (@(posedge clk) disable iff (!rstN)
    (stb.updOv && !stb.writeStat) |=> (soQ || !ovQ));

  // R7: negate writes the same value to both overflow copies
  p_neg_pair_r7: assert property (@(posedge clk) disable iff (!rstN)
    (stb.updOv && stb.ovSrc == OVS_NEG && !stb.writeStat) |=> (ovQ == ov32Q));

  // R9: condition register still unless a move is issued
  p_cr_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !stb.writeCr |=> $stable(crQ));

  // R10: result untouched by status writes and condition moves
  p_res_hold_r10: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadRes |=> $stable(resQ));

endmodule

// File: rtl/fxu_flag_unit.sv
module fxu_flag_unit
  import fxu_flag_pkg::*;
#(
  parameter int DATA_W    = 64,
  parameter int CR_FIELDS = 8,
  parameter int FIELD_W   = 4,
  localparam int CR_W     = CR_FIELDS * FIELD_W,
  localparam int SEL_W    = $clog2(CR_FIELDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opSel,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              carryIn,
  input  logic              mode64,
  input  logic              oeEn,
  input  logic              wordOp,
  input  logic              extOv32,
  input  logic              extOv64,
  input  logic [SEL_W-1:0]  crSel,
  output logic [DATA_W-1:0] result,
  output logic [STAT_W-1:0] status,
  output logic [CR_W-1:0]   condReg
);

  fxuStrobe_t stb;

  fxu_flag_ctrl u_ctrl (
    .opValid (opValid),
    .opSel   (opSel),
    .oeEn    (oeEn),
    .stb     (stb)
  );

  fxu_flag_datapath #(
    .DATA_W    (DATA_W),
    .CR_FIELDS (CR_FIELDS),
    .FIELD_W   (FIELD_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .opA     (opA),
    .opB     (opB),
    .carryIn (carryIn),
    .mode64  (mode64),
    .wordOp  (wordOp),
    .extOv32 (extOv32),
    .extOv64 (extOv64),
    .crSel   (crSel),
    .resQ    (result),
    .statQ   (status),
    .crQ     (condReg)
  );

endmodule

// File: tb/tb_fxu_flag_unit.sv
module tb_fxu_flag_unit;

  logic        clk = 1'b0;
  logic        rstN;
  logic        opValid;
  logic [2:0]  opSel;
  logic [63:0] opA, opB;
  logic        carryIn, mode64, oeEn, wordOp, extOv32, extOv64;
  logic [2:0]  crSel;
  logic [63:0] result;
  logic [4:0]  status;
  logic [31:0] condReg;

  int checks = 0;
  int fails  = 0;

  // behavioural model state
  logic [63:0] mRes;
  logic        mSo, mOv, mOv32, mCa, mCa32;
  logic [31:0] mCr;

  localparam logic [63:0] MIN64 = 64'h8000_0000_0000_0000;

  always #5 clk = ~clk;

  fxu_flag_unit dut (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opSel(opSel), .opA(opA), .opB(opB),
    .carryIn(carryIn), .mode64(mode64), .oeEn(oeEn), .wordOp(wordOp),
    .extOv32(extOv32), .extOv64(extOv64), .crSel(crSel),
    .result(result), .status(status), .condReg(condReg)
  );

  task automatic compare(input string tag);
    logic [100:0] act, exp;
    act = {result, status, condReg};
    exp = {mRes, mSo, mOv, mOv32, mCa, mCa32, mCr};
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual res=%h st=%b cr=%h expected res=%h st=%b cr=%h",
               tag, result, status, condReg, mRes,
               {mSo, mOv, mOv32, mCa, mCa32}, mCr);
    end
  endtask

  // model advances one operation
  task automatic modelStep(input logic [2:0] op, input logic [63:0] a, b,
                           input logic ci, m64, oe, word, e32, e64,
                           input logic [2:0] sel);
    logic [63:0] x;
    logic        c;
    logic [64:0] full, sw;
    logic [32:0] lo, sl;
    logic        ov64, ov32, f;
    case (op)
      3'd0, 3'd1, 3'd2, 3'd3: begin
        x = (op == 3'd1 || op == 3'd3) ? ~a : a;
        c = (op == 3'd0) ? 1'b0 : (op == 3'd1) ? 1'b1 : ci;
        full = {1'b0, x} + {1'b0, b} + 65'(c);
        lo   = {1'b0, x[31:0]} + {1'b0, b[31:0]} + 33'(c);
        sw   = {x[63], x} + {b[63], b} + 65'(c);
        sl   = {x[31], x[31:0]} + {b[31], b[31:0]} + 33'(c);
        ov64 = sw[64] != sw[63];
        ov32 = sl[32] != sl[31];
        mRes  = full[63:0];
        mCa   = m64 ? full[64] : lo[32];
        mCa32 = lo[32];
        if (oe) begin
          mOv   = m64 ? ov64 : ov32;
          mOv32 = ov32;
          mSo   = mSo | mOv;
        end
      end
      3'd4: begin
        mRes = 64'd0 - a;
        if (oe) begin
          f = m64 ? (a == MIN64) : (a[31:0] == 32'h8000_0000);
          mOv = f; mOv32 = f; mSo = mSo | f;
        end
      end
      3'd5: begin
        mRes = a;
        if (oe) begin
          f = word ? e32 : e64;
          mOv = f; mOv32 = f; mSo = mSo | f;
        end
      end
      3'd6: mCr[31 - 4*sel -: 4] = {mOv, mOv32, mCa, mCa32};
      default: {mSo, mOv, mOv32, mCa, mCa32} = a[4:0];
    endcase
  endtask

  task automatic doOp(input logic [2:0] op, input logic [63:0] a, b,
                      input logic ci, m64, oe, word, e32, e64,
                      input logic [2:0] sel, input string tag);
    opValid = 1'b1; opSel = op; opA = a; opB = b; carryIn = ci; mode64 = m64;
    oeEn = oe; wordOp = word; extOv32 = e32; extOv64 = e64; crSel = sel;
    modelStep(op, a, b, ci, m64, oe, word, e32, e64, sel);
    @(posedge clk); #1;
    compare(tag);
  endtask

  task automatic idle(input logic [2:0] op, input string tag);
    opValid = 1'b0; opSel = op; opA = '1; opB = '1; carryIn = 1'b1; oeEn = 1'b1;
    extOv32 = 1'b1; extOv64 = 1'b1;
    @(posedge clk); #1;
    compare(tag);
  endtask

  function automatic string tagFor(input logic [2:0] op);
    case (op)
      3'd4: return "R7";
      3'd5: return "R8";
      3'd6: return "R9";
      3'd7: return "R10";
      default: return "R2";
    endcase
  endfunction

  function automatic logic [63:0] pick();
    case ($urandom % 8)
      0: return MIN64;
      1: return 64'h0000_0000_8000_0000;
      2: return 64'hFFFF_FFFF_FFFF_FFFF;
      3: return 64'h0000_0000_FFFF_FFFF;
      4: return 64'h7FFF_FFFF_7FFF_FFFF;
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin
    #2_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rstN = 1'b0; opValid = 1'b0; opSel = '0; opA = '0; opB = '0; carryIn = 1'b0;
    mode64 = 1'b1; oeEn = 1'b0; wordOp = 1'b0; extOv32 = 1'b0; extOv64 = 1'b0;
    crSel = '0;
    mRes = '0; {mSo, mOv, mOv32, mCa, mCa32} = '0; mCr = '0;
    repeat (3) @(posedge clk);
    #1;
    compare("R1");
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk); #1;

    // R2/R3: carry at bit 31 only, both modes
    doOp(3'd0, 64'h0000_0000_FFFF_FFFF, 64'd1, 0, 1, 0, 0, 0, 0, 0, "R2");
    doOp(3'd0, 64'h0000_0000_FFFF_FFFF, 64'd1, 0, 0, 0, 0, 0, 0, 0, "R3");
    // carry at bit 63 only
    doOp(3'd0, 64'hFFFF_FFFF_0000_0000, 64'h0000_0001_0000_0000, 0, 1, 0, 0, 0, 0, 0, "R2");
    doOp(3'd0, 64'hFFFF_FFFF_0000_0000, 64'h0000_0001_0000_0000, 0, 0, 0, 0, 0, 0, 0, "R3");
    // R4: subtract-from updates carry with oeEn low
    doOp(3'd1, 64'd5, 64'd9, 0, 1, 0, 0, 0, 0, 0, "R4");
    doOp(3'd3, 64'd9, 64'd5, 0, 1, 0, 0, 0, 0, 0, "R4");
    doOp(3'd2, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0, 1, 1, 0, 0, 0, 0, 0, "R4");
    // R5: 32-bit overflow only, then 64-bit only
    doOp(3'd0, 64'h0000_0000_7FFF_FFFF, 64'd1, 0, 1, 1, 0, 0, 0, 0, "R5");
    doOp(3'd0, 64'h0000_0000_7FFF_FFFF, 64'd1, 0, 0, 1, 0, 0, 0, 0, "R5");
    doOp(3'd0, 64'h7FFF_FFFF_0000_0000, 64'h0000_0001_0000_0000, 0, 1, 1, 0, 0, 0, 0, "R5");
    doOp(3'd0, 64'd1, 64'd1, 0, 1, 1, 0, 0, 0, 0, "R5");
    // R5: no overflow update with oeEn low
    doOp(3'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'd1, 0, 1, 0, 0, 0, 0, 0, "R5");
    // R6: SO stays, then cleared by status write
    doOp(3'd0, 64'd2, 64'd2, 0, 1, 1, 0, 0, 0, 0, "R6");
    doOp(3'd7, 64'd0, 64'd0, 0, 1, 0, 0, 0, 0, 0, "R6");
    // R7: most negative values in each mode
    doOp(3'd4, MIN64, 64'd0, 0, 1, 1, 0, 0, 0, 0, "R7");
    doOp(3'd7, 64'd0, 64'd0, 0, 1, 0, 0, 0, 0, 0, "R10");
    doOp(3'd4, MIN64, 64'd0, 0, 0, 1, 0, 0, 0, 0, "R7");
    doOp(3'd4, 64'h0000_0000_8000_0000, 64'd0, 0, 0, 1, 0, 0, 0, 0, "R7");
    doOp(3'd4, 64'h0000_0000_8000_0000, 64'd0, 0, 1, 1, 0, 0, 0, 0, "R7");
    doOp(3'd4, 64'd7, 64'd0, 0, 1, 0, 0, 0, 0, 0, "R7");
    // R8: word vs doubleword overflow sources
    doOp(3'd8 - 3'd3, 64'h1234, 64'd0, 0, 1, 1, 1, 1, 0, 0, "R8");
    doOp(3'd5, 64'h5678, 64'd0, 0, 1, 1, 1, 0, 1, 0, "R8");
    doOp(3'd5, 64'h9abc, 64'd0, 0, 1, 1, 0, 0, 1, 0, "R8");
    // R9: first and last fields
    doOp(3'd0, 64'h0000_0000_FFFF_FFFF, 64'd1, 0, 1, 1, 0, 0, 0, 0, "R9");
    doOp(3'd6, 64'd0, 64'd0, 0, 1, 0, 0, 0, 0, 0, "R9");
    doOp(3'd6, 64'd0, 64'd0, 0, 1, 0, 0, 0, 0, 7, "R9");
    // R10: status write of a pattern
    doOp(3'd7, 64'h15, 64'd0, 0, 1, 0, 0, 0, 0, 0, "R10");
    doOp(3'd6, 64'd0, 64'd0, 0, 1, 0, 0, 0, 0, 3, "R10");
    // R11: nothing moves while opValid is low
    for (int k = 0; k < 8; k++) idle(3'(k), "R11");

    for (int n = 0; n < 400; n++) begin
      logic [2:0] op;
      op = 3'($urandom % 8);
      doOp(op, pick(), pick(), 1'($urandom), 1'($urandom), 1'($urandom),
           1'($urandom), 1'($urandom), 1'($urandom), 3'($urandom), tagFor(op));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule